// File: doc/BRIEF.md
# Fetch Address Match Opcode Substituter

This block sits on the instruction fetch path of a small CPU, between program memory and the decoder. It holds two programmable 24-bit program addresses. Each has its own compare enable. When a valid fetch presents an address that equals an enabled stored address, the block replaces the opcode byte going to the CPU with the one-byte software interrupt opcode (0x01). The CPU then enters that interrupt's handler instead of executing the original instruction. The handler can then run whatever patch or debug action software has set up for that location.

Software programs the block over a byte-wide register bus. Each address is loaded as three byte registers. A control register turns each comparator on or off. The substitution is purely combinational, so the fetch path gains no cycle. Register writes take effect from the next clock edge.

Top module: `fetch_trap_patcher`

## Requirements
- R1: After reset both comparators are disabled and the control register reads 0x00, so every fetch passes the memory opcode through and `trapHit` stays low.
- R2: When `fetchValid` is high and `fetchAddr` equals the address of an enabled comparator, `opcodeOut` is 0x01 and `trapHit` is high in the same cycle.
- R3: When no enabled comparator matches, `opcodeOut` equals `memOpcode` and `trapHit` is low.
- R4: Comparator 0 keeps its address bytes at register offsets 0x1FF0 (bits 7:0), 0x1FF1 (bits 15:8) and 0x1FF2 (bits 23:16). Comparator 1 keeps them at 0x1FF3, 0x1FF4 and 0x1FF5 in the same byte order. Each byte reads back the value last written to it.
- R5: The control register is at offset 0x009E. Bit 1 enables comparator 0 and bit 3 enables comparator 1. The other six bits read as 0 and ignore writes.
- R6: While `fetchValid` is low, no substitution occurs, whatever the fetch address is.
- R7: A match needs all 24 address bits to be equal. A fetch address that differs from a stored address in any single bit, low, middle or high byte, does not substitute.
- R8: When both comparators are enabled and both hold the fetch address, the result is the same single substitution: `opcodeOut` is 0x01 and `trapHit` is high.
- R9: A register write changes matching behaviour only from the clock edge that captures it. In the cycle in which the write is presented, the fetch path still uses the old settings.
- R10: Register reads of offsets that belong to no register return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 16 | Register bus offset |
| regWrData | input | 8 | Register write data |
| regWr | input | 1 | Register write strobe, captured at the rising edge |
| regRdData | output | 8 | Combinational register read data for `regAddr` |
| fetchAddr | input | 24 | Address of the current instruction fetch |
| fetchValid | input | 1 | Fetch address and memory opcode are valid |
| memOpcode | input | 8 | Opcode byte returned by program memory |
| opcodeOut | output | 8 | Opcode byte delivered to the CPU |
| trapHit | output | 1 | High in each cycle in which a substitution occurs |

## Verification
The bench builds the block with its default parameters: two comparators, the 0x1FF0 address register base, the 0x009E control offset and the 0x01 interrupt opcode. These values put both enable bit positions within reach, along with all six address byte offsets and the boundaries just outside that window. They also cover the case where both comparators hold the same address. Single-bit mismatches in each of the three address bytes test that the compare spans the full width. A write and a fetch presented in the same cycle show that the new settings apply only from the next edge.

// File: rtl/fetch_trap_pkg.sv
package fetch_trap_pkg;

  localparam int CMP_COUNT  = 2;
  localparam int ADDR_BYTES = 3;
  localparam int BYTE_W     = 8;
  localparam int ADDR_W     = ADDR_BYTES * BYTE_W;
  localparam int STB_W      = CMP_COUNT * ADDR_BYTES;
  localparam int FLAT_W     = CMP_COUNT * ADDR_W;

  // Strobes from register decode into the datapath.
  typedef struct packed {
    logic [STB_W-1:0]  byteWr;  // one per stored address byte, comparator-major
    logic              ctrlWr;  // control register write
    logic [BYTE_W-1:0] wrData;
  } regStrobe_t;

  // Control register bit holding the enable of comparator idx.
  function automatic int enBitPos(input int idx);
    return 2 * idx + 1;
  endfunction

endpackage

// File: rtl/trap_reg_ctrl.sv
module trap_reg_ctrl
  import fetch_trap_pkg::*;
#(
  parameter int                    REG_ADDR_W = 16,
  parameter logic [REG_ADDR_W-1:0] CMP_BASE   = 16'h1FF0,
  parameter logic [REG_ADDR_W-1:0] CTRL_OFS   = 16'h009E
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0]     regWrData,
  input  logic                  regWr,
  input  logic [FLAT_W-1:0]     cmpAddrFlat,
  input  logic [CMP_COUNT-1:0]  cmpEn,
  output logic [BYTE_W-1:0]     regRdData,
  output regStrobe_t            stb
);

  logic [STB_W-1:0] byteSel;
  logic             ctrlSel;

  // Address byte s lives at CMP_BASE + s; flat bits s*BYTE_W upward.
  generate
    for (genvar s = 0; s < STB_W; s++) begin : g_byteSel
      assign byteSel[s] = (regAddr == CMP_BASE + REG_ADDR_W'(s));
    end
  endgenerate

  assign ctrlSel = (regAddr == CTRL_OFS);

  always_comb begin
    stb.byteWr = byteSel & {STB_W{regWr}};
    stb.ctrlWr = ctrlSel & regWr;
    stb.wrData = regWrData;
  end

  always_comb begin
    regRdData = '0;
    for (int s = 0; s < STB_W; s++) begin
      if (byteSel[s]) regRdData = cmpAddrFlat[s*BYTE_W +: BYTE_W];
    end
    if (ctrlSel) begin
      for (int c = 0; c < CMP_COUNT; c++) begin
        regRdData[enBitPos(c)] = cmpEn[c];
      end
    end
  end

  // At most one register is written per cycle.
  AST_ONE_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.byteWr, stb.ctrlWr})) else $error("AST_ONE_WRITE_TARGET"); // R4
  // Unmapped offsets read as zero.
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (!(|byteSel) && !ctrlSel) |-> (regRdData == '0)) else $error("AST_UNMAPPED_ZERO"); // R10

endmodule

// File: rtl/trap_datapath.sv
module trap_datapath
  import fetch_trap_pkg::*;
#(
  parameter logic [BYTE_W-1:0] TRAP_OPC = 8'h01
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  regStrobe_t           stb,
  input  logic [ADDR_W-1:0]    fetchAddr,
  input  logic                 fetchValid,
  input  logic [BYTE_W-1:0]    memOpcode,
  output logic [BYTE_W-1:0]    opcodeOut,
  output logic                 trapHit,
  output logic [FLAT_W-1:0]    cmpAddrFlat,
  output logic [CMP_COUNT-1:0] cmpEn
);

  logic [FLAT_W-1:0]    addrQ;
  logic [CMP_COUNT-1:0] enQ;
  logic [CMP_COUNT-1:0] hit;

  // Address bytes carry no reset value; software loads them before enabling.
  generate
    for (genvar s = 0; s < STB_W; s++) begin : g_addrByte
      always_ff @(posedge clk) begin
        if (stb.byteWr[s]) addrQ[s*BYTE_W +: BYTE_W] <= stb.wrData;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ <= '0;
    end else if (stb.ctrlWr) begin
      for (int c = 0; c < CMP_COUNT; c++) begin
        enQ[c] <= stb.wrData[enBitPos(c)];
      end
    end
  end

  generate
    for (genvar c = 0; c < CMP_COUNT; c++) begin : g_cmp
      assign hit[c] = fetchValid && enQ[c] &&
                      (fetchAddr == addrQ[c*ADDR_W +: ADDR_W]);
    end
  endgenerate

  assign trapHit     = |hit;
  assign opcodeOut   = trapHit ? TRAP_OPC : memOpcode;
  assign cmpAddrFlat = addrQ;
  assign cmpEn       = enQ;

  AST_HIT_GIVES_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    trapHit |-> (opcodeOut == TRAP_OPC)) else $error("AST_HIT_GIVES_TRAP"); // R2
  AST_NO_HIT_PASSES: assert property (@(posedge clk) disable iff (!rstN)
    !trapHit |-> (opcodeOut == memOpcode)) else $error("AST_NO_HIT_PASSES"); // R3
  AST_IDLE_FETCH_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !fetchValid |-> !trapHit) else $error("AST_IDLE_FETCH_QUIET"); // R6
  AST_EN0_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    stb.ctrlWr |=> (cmpEn[0] == $past(stb.wrData[1]))) else $error("AST_EN0_FOLLOWS_WRITE"); // R5
  AST_EN_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !stb.ctrlWr |=> $stable(cmpEn)) else $error("AST_EN_HOLDS"); // R9
  AST_ADDR_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !(|stb.byteWr) |=> $stable(cmpAddrFlat)) else $error("AST_ADDR_HOLDS"); // R4

endmodule

// File: rtl/fetch_trap_patcher.sv
module fetch_trap_patcher
  import fetch_trap_pkg::*;
#(
  parameter int                    REG_ADDR_W = 16,
  parameter logic [REG_ADDR_W-1:0] CMP_BASE   = 16'h1FF0,
  parameter logic [REG_ADDR_W-1:0] CTRL_OFS   = 16'h009E,
  parameter logic [7:0]            TRAP_OPC   = 8'h01
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [7:0]            regWrData,
  input  logic                  regWr,
  output logic [7:0]            regRdData,
  input  logic [23:0]           fetchAddr,
  input  logic                  fetchValid,
  input  logic [7:0]            memOpcode,
  output logic [7:0]            opcodeOut,
  output logic                  trapHit
);

  regStrobe_t           stb;
  logic [FLAT_W-1:0]    cmpAddrFlat;
  logic [CMP_COUNT-1:0] cmpEn;

  trap_reg_ctrl #(
    .REG_ADDR_W (REG_ADDR_W),
    .CMP_BASE   (CMP_BASE),
    .CTRL_OFS   (CTRL_OFS)
  ) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .regWr       (regWr),
    .cmpAddrFlat (cmpAddrFlat),
    .cmpEn       (cmpEn),
    .regRdData   (regRdData),
    .stb         (stb)
  );

  trap_datapath #(
    .TRAP_OPC (TRAP_OPC)
  ) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .fetchAddr   (fetchAddr),
    .fetchValid  (fetchValid),
    .memOpcode   (memOpcode),
    .opcodeOut   (opcodeOut),
    .trapHit     (trapHit),
    .cmpAddrFlat (cmpAddrFlat),
    .cmpEn       (cmpEn)
  );

  // Both comparators matching still yields one ordinary substitution.
  AST_DUAL_HIT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (uPath.hit == 2'b11) |-> (trapHit && opcodeOut == TRAP_OPC)) else $error("AST_DUAL_HIT_SINGLE"); // R8

endmodule

// File: tb/fetch_trap_patcher_test.sv
module fetch_trap_patcher_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic        regWr = 1'b0;
  logic [7:0]  regRdData;
  logic [23:0] fetchAddr = '0;
  logic        fetchValid = 1'b0;
  logic [7:0]  memOpcode = '0;
  logic [7:0]  opcodeOut;
  logic        trapHit;

  int checks = 0;
  int errors = 0;

  localparam logic [23:0] ADDR_A = 24'h123456;
  localparam logic [23:0] ADDR_B = 24'hABCDEF;

  always #2.5 clk = ~clk;  // 200 MHz

  fetch_trap_patcher uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrData(regWrData),
    .regWr(regWr), .regRdData(regRdData), .fetchAddr(fetchAddr),
    .fetchValid(fetchValid), .memOpcode(memOpcode), .opcodeOut(opcodeOut),
    .trapHit(trapHit)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic loadCmp(input int idx, input logic [23:0] a);
    for (int b = 0; b < 3; b++) begin
      regWrite(16'h1FF0 + 16'(idx * 3 + b), a[b*8 +: 8]);
    end
  endtask

  task automatic fetchCheck(input string req, input logic [23:0] a, input logic v,
                            input logic [7:0] mem, input logic expHit);
    @(negedge clk);
    fetchAddr = a; fetchValid = v; memOpcode = mem;
    #1;
    chk(req, {24'h0, opcodeOut}, expHit ? 32'h01 : {24'h0, mem});
    chk(req, {31'h0, trapHit}, {31'h0, expHit});
  endtask

  task automatic testReset();
    logic [7:0] d;
    regRead(16'h009E, d);
    chk("R1 ctrl reset", {24'h0, d}, 32'h00);
    fetchCheck("R1 no trap after reset", 24'h000000, 1'b1, 8'h5A, 1'b0);
  endtask

  task automatic testRegMap();
    logic [7:0] d;
    loadCmp(0, ADDR_A);
    loadCmp(1, ADDR_B);
    for (int c = 0; c < 2; c++) begin
      for (int b = 0; b < 3; b++) begin
        regRead(16'h1FF0 + 16'(c * 3 + b), d);
        chk("R4 byte readback", {24'h0, d},
            {24'h0, (c == 0) ? ADDR_A[b*8 +: 8] : ADDR_B[b*8 +: 8]});
      end
    end
  endtask

  task automatic testCtrlBits();
    logic [7:0] d;
    regWrite(16'h009E, 8'hFF);
    regRead(16'h009E, d);
    chk("R5 reserved bits read zero", {24'h0, d}, 32'h0A);
    regWrite(16'h009E, 8'hF5);
    regRead(16'h009E, d);
    chk("R5 enables cleared by write", {24'h0, d}, 32'h00);
    fetchCheck("R5 reserved writes do not enable", ADDR_A, 1'b1, 8'h33, 1'b0);
  endtask

  task automatic testMatch0();
    regWrite(16'h009E, 8'h02);
    fetchCheck("R2 comparator 0 hit", ADDR_A, 1'b1, 8'h9C, 1'b1);
    fetchCheck("R3 comparator 1 disabled", ADDR_B, 1'b1, 8'h9C, 1'b0);
    fetchCheck("R3 unrelated address", 24'h000100, 1'b1, 8'h77, 1'b0);
  endtask

  task automatic testMatch1();
    regWrite(16'h009E, 8'h08);
    fetchCheck("R5 bit 3 enables comparator 1", ADDR_B, 1'b1, 8'hC3, 1'b1);
    fetchCheck("R5 comparator 0 off with bit 1 clear", ADDR_A, 1'b1, 8'hC3, 1'b0);
  endtask

  task automatic testValid();
    regWrite(16'h009E, 8'h0A);
    fetchCheck("R6 no trap without fetchValid", ADDR_A, 1'b0, 8'h44, 1'b0);
    fetchCheck("R6 no trap without fetchValid", ADDR_B, 1'b0, 8'h45, 1'b0);
  endtask

  task automatic testFullCompare();
    fetchCheck("R7 low byte bit differs", ADDR_A ^ 24'h000001, 1'b1, 8'h11, 1'b0);
    fetchCheck("R7 middle byte bit differs", ADDR_A ^ 24'h001000, 1'b1, 8'h12, 1'b0);
    fetchCheck("R7 high byte bit differs", ADDR_A ^ 24'h800000, 1'b1, 8'h13, 1'b0);
    fetchCheck("R7 exact match still hits", ADDR_A, 1'b1, 8'h14, 1'b1);
  endtask

  task automatic testBoth();
    loadCmp(1, ADDR_A);
    fetchCheck("R8 both comparators match", ADDR_A, 1'b1, 8'hE7, 1'b1);
    loadCmp(1, ADDR_B);
  endtask

  task automatic testWriteTiming();
    regWrite(16'h009E, 8'h00);
    @(negedge clk);
    regAddr = 16'h009E; regWrData = 8'h02; regWr = 1'b1;
    fetchAddr = ADDR_A; fetchValid = 1'b1; memOpcode = 8'h66;
    #1;
    chk("R9 old setting in write cycle", {31'h0, trapHit}, 32'h0);
    chk("R9 old setting in write cycle", {24'h0, opcodeOut}, 32'h66);
    @(posedge clk);
    #1;
    regWr = 1'b0;
    chk("R9 new setting after edge", {31'h0, trapHit}, 32'h1);
    chk("R9 new setting after edge", {24'h0, opcodeOut}, 32'h01);
  endtask

  task automatic testUnmapped();
    logic [7:0] d;
    regRead(16'h1FF6, d);
    chk("R10 read past address window", {24'h0, d}, 32'h00);
    regRead(16'h1FEF, d);
    chk("R10 read before address window", {24'h0, d}, 32'h00);
    regRead(16'h009F, d);
    chk("R10 read next to control", {24'h0, d}, 32'h00);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRegMap();
    testCtrlBits();
    testMatch0();
    testMatch1();
    testValid();
    testFullCompare();
    testBoth();
    testWriteTiming();
    testUnmapped();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule